// File: doc/BRIEF.md
# Dual-Bank Memory Front-End Selector

This block sits behind the pins of a combined memory device that holds a byte-wide nonvolatile (flash) bank and a byte-wide static RAM bank. Both banks share one address bus, one data bus, a write strobe and an output enable. Each bank has its own active-low select. The host strobes are asynchronous. The block brings them, together with address and data, into the core clock domain through a two-stage synchronizer. It then decides which bank an access targets.

SRAM accesses are served locally from an inferred array that decodes only the low `SRAM_AW` address bits. The full product uses 17 bits (128 KB at the bottom of the address space). The default of 10 keeps the model small. Flash reads are forwarded to an external command unit as a read address, and the returned byte is driven onto the bus. A flash write is qualified by the write-inhibit rules and a minimum-width glitch filter. It is then offered to the command unit on a valid/ready channel.

The valid/ready channel follows these rules:
- Once `fcmd_valid` rises, it holds with a stable address and data until `fcmd_ready` is seen high at a clock edge.
- A new qualified write that arrives while an offer is still pending is discarded.
- Qualified writes that end while the command unit reports busy are not offered.

SRAM traffic is never stalled by the flash side.

Top module: `dual_bank_frontend`

## Requirements
- R1: When the flash select and the SRAM select are both low, the access is a flash access. The SRAM array is not written, and a read drives the flash byte (`fl_read_data`) onto the bus.
- R2: With both selects high, `standby` is 1, `host_dout_en` is 0 and `fl_read_en` is 0.
- R3: An SRAM read (SRAM select low, flash select high, output enable low, write strobe high) drives the stored byte on `host_dout` with `host_dout_en`=1, three clock edges after the inputs settle.
- R4: An SRAM write happens while the SRAM select is low and the write strobe is low, with output enable at either level. The address and data of the last synchronized cycle of that window are stored when the window ends, whether the strobe or the select rises first.
- R5: The SRAM decodes only address bits [SRAM_AW-1:0]. Addresses that differ only above them reach the same byte.
- R6: While output enable is high, `host_dout_en` is 0.
- R7: No flash command is produced from a window in which output enable is low, the flash select is high, or the write strobe is high.
- R8: A flash write window shorter than MIN_PULSE_CYC synchronized cycles produces no command. MIN_PULSE_CYC is ceil(GLITCH_PS/CLK_PS), which is 3 by default and stands for 5 ns. A window of at least that length produces one command carrying that window's address and data.
- R9: While `fl_busy` is 1, SRAM reads and writes are served as usual, and flash write windows ending then produce no command.
- R10: `fcmd_valid` stays high with stable `fcmd_addr`/`fcmd_data` until a clock edge with `fcmd_ready` high clears it. A qualified write arriving while an offer is pending is dropped.
- R11: After reset, `host_dout_en`=0, `fcmd_valid`=0 and `standby`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W | Shared address bus |
| host_din | input | DATA_W | Data bus, host to device |
| host_flash_en_n | input | 1 | Flash bank select, active low |
| host_sram_en_n | input | 1 | SRAM bank select, active low |
| host_we_n | input | 1 | Write strobe, active low |
| host_oe_n | input | 1 | Output enable, active low |
| host_dout | output | DATA_W | Data bus, device to host |
| host_dout_en | output | 1 | Bus drive enable; 0 means high impedance |
| standby | output | 1 | Both banks deselected |
| fl_read_en | output | 1 | Flash read in progress |
| fl_read_addr | output | ADDR_W | Synchronized address for the flash read |
| fl_read_data | input | DATA_W | Byte returned by the flash command unit |
| fl_busy | input | 1 | Flash internal program/erase in progress |
| fcmd_valid | output | 1 | Flash write command offered |
| fcmd_ready | input | 1 | Command unit accepts the offer |
| fcmd_addr | output | ADDR_W | Command address |
| fcmd_data | output | DATA_W | Command data |

## Verification
The checker watches every cycle for the following:
- the offer channel holding steady under back-pressure;
- no command ever rising without a preceding qualified write window of at least the minimum length, ended while not busy;
- the SRAM write window staying closed whenever the flash select is low;
- no flash read while in standby.

Only the directed scenarios can show the stored contents and the aliasing of SRAM addresses, or that the byte written comes from the last cycle of the window when the select, rather than the strobe, ends it. The same holds for a flash-select-wins read returning the flash byte, and for a dropped second command that never appears after the first is consumed.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  typedef struct packed {
    logic flash_en_n;
    logic sram_en_n;
    logic we_n;
    logic oe_n;
  } strobe_t;

  typedef enum logic [1:0] {
    BANK_NONE  = 2'd0,
    BANK_SRAM  = 2'd1,
    BANK_FLASH = 2'd2
  } bank_t;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= {W{RST_VAL}};
      end else if (s == 0) begin
        stage_q[s] <= d;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dbf_decode.sv
module dbf_decode
  import dbf_pkg::*;
(
  input  strobe_t s,
  output bank_t   bank,
  output logic    sram_rd,
  output logic    sram_wr_win,
  output logic    flash_rd,
  output logic    flash_wr_ok,
  output logic    standby
);

  always_comb begin
    // flash select dominates; SRAM select only counts with flash idle
    if (!s.flash_en_n)      bank = BANK_FLASH;
    else if (!s.sram_en_n)  bank = BANK_SRAM;
    else                    bank = BANK_NONE;
  end

  assign standby     = (bank == BANK_NONE);
  assign sram_rd     = (bank == BANK_SRAM)  &&  s.we_n && !s.oe_n;
  assign sram_wr_win = (bank == BANK_SRAM)  && !s.we_n;
  assign flash_rd    = (bank == BANK_FLASH) &&  s.we_n && !s.oe_n;
  // write inhibit: output enable low, select high or strobe high blocks it
  assign flash_wr_ok = (bank == BANK_FLASH) && !s.we_n &&  s.oe_n;

endmodule

// File: rtl/dbf_sram.sv
module dbf_sram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_win,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          win_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      win_q <= wr_win;
      if (wr_win) begin
        addr_q <= addr;
        data_q <= wdata;
      end
    end
  end

  // window closes on whichever of select or strobe rises first
  assign commit = win_q && !wr_win;

  always_ff @(posedge clk) begin
    if (commit) mem[addr_q] <= data_q;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/dbf_flash_wr.sv
module dbf_flash_wr #(
  parameter int unsigned AW      = 19,
  parameter int unsigned DW      = 8,
  parameter int unsigned MIN_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);

  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_CYC);

  logic [CW-1:0] run_q;
  logic          ok_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          window_end;
  logic          long_enough;
  logic          issue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      ok_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ok_q <= wr_ok;
      if (wr_ok) begin
        addr_q <= addr;
        data_q <= wdata;
        if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end

  assign window_end  = ok_q && !wr_ok;
  assign long_enough = (run_q >= CNT_MAX);
  assign issue       = window_end && long_enough && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
      if (issue && !cmd_valid) begin
        cmd_valid <= 1'b1;
        cmd_addr  <= addr_q;
        cmd_data  <= data_q;
      end
    end
  end

endmodule

// File: rtl/dual_bank_frontend.sv
module dual_bank_frontend
  import dbf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SRAM_AW   = 10,
  parameter int unsigned CLK_PS    = 2000,
  parameter int unsigned GLITCH_PS = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_din,
  input  logic              host_flash_en_n,
  input  logic              host_sram_en_n,
  input  logic              host_we_n,
  input  logic              host_oe_n,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_dout_en,
  output logic              standby,
  output logic              fl_read_en,
  output logic [ADDR_W-1:0] fl_read_addr,
  input  logic [DATA_W-1:0] fl_read_data,
  input  logic              fl_busy,
  output logic              fcmd_valid,
  input  logic              fcmd_ready,
  output logic [ADDR_W-1:0] fcmd_addr,
  output logic [DATA_W-1:0] fcmd_data
);

  localparam int unsigned MIN_PULSE_CYC = ceil_div(GLITCH_PS, CLK_PS);
  localparam int unsigned STRB_W        = $bits(strobe_t);
  localparam int unsigned BUS_W         = ADDR_W + DATA_W;

  strobe_t           strb_raw;
  strobe_t           strb_s;
  logic [BUS_W-1:0]  bus_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;

  bank_t             bank;
  logic              sram_rd;
  logic              sram_wr_win;
  logic              flash_rd;
  logic              flash_wr_ok;
  logic [DATA_W-1:0] sram_rdata;

  assign strb_raw = '{flash_en_n: host_flash_en_n, sram_en_n: host_sram_en_n,
                      we_n: host_we_n, oe_n: host_oe_n};

  dbf_sync #(.W(STRB_W), .STAGES(2), .RST_VAL(1'b1)) i_strb_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   (strb_raw),
    .q   (strb_s)
  );

  // address and data ride the same two stages so they stay aligned
  dbf_sync #(.W(BUS_W), .STAGES(2), .RST_VAL(1'b0)) i_bus_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({host_addr, host_din}),
    .q   (bus_s)
  );

  assign addr_s = bus_s[BUS_W-1:DATA_W];
  assign data_s = bus_s[DATA_W-1:0];

  dbf_decode i_decode (
    .s           (strb_s),
    .bank        (bank),
    .sram_rd     (sram_rd),
    .sram_wr_win (sram_wr_win),
    .flash_rd    (flash_rd),
    .flash_wr_ok (flash_wr_ok),
    .standby     (standby)
  );

  dbf_sram #(.AW(SRAM_AW), .DW(DATA_W)) i_sram (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_win (sram_wr_win),
    .addr   (addr_s[SRAM_AW-1:0]),
    .wdata  (data_s),
    .rdata  (sram_rdata)
  );

  dbf_flash_wr #(.AW(ADDR_W), .DW(DATA_W), .MIN_CYC(MIN_PULSE_CYC)) i_flash_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ok     (flash_wr_ok),
    .addr      (addr_s),
    .wdata     (data_s),
    .busy      (fl_busy),
    .cmd_valid (fcmd_valid),
    .cmd_ready (fcmd_ready),
    .cmd_addr  (fcmd_addr),
    .cmd_data  (fcmd_data)
  );

  assign fl_read_en   = flash_rd;
  assign fl_read_addr = addr_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_dout_en <= 1'b0;
      host_dout    <= '0;
    end else begin
      host_dout_en <= sram_rd || flash_rd;
      host_dout    <= (bank == BANK_SRAM) ? sram_rdata : fl_read_data;
    end
  end

endmodule

// File: rtl/dbf_checker.sv
module dbf_checker #(
  parameter int unsigned MIN_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic flash_sel_n,
  input logic sram_wr_win,
  input logic flash_wr_ok,
  input logic standby,
  input logic fl_read_en,
  input logic fl_busy,
  input logic fcmd_valid,
  input logic fcmd_ready,
  input logic [31:0] fcmd_word
);

  logic [7:0] run_q;
  logic [7:0] last_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= '0;
      last_run_q <= '0;
    end else if (flash_wr_ok) begin
      if (run_q != 8'hFF) run_q <= run_q + 8'd1;
    end else begin
      last_run_q <= run_q;
      run_q      <= '0;
    end
  end

  // R1
  sram_closed_on_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_sel_n |-> !sram_wr_win);

  // R2
  standby_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !fl_read_en);

  // R7
  cmd_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fcmd_valid) |-> $past(flash_wr_ok, 2));

  // R8
  cmd_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fcmd_valid) |-> (last_run_q >= 8'(MIN_CYC)));

  // R9
  cmd_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fcmd_valid) |-> !$past(fl_busy));

  // R10
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fcmd_valid && !fcmd_ready) |=> (fcmd_valid && $stable(fcmd_word)));

endmodule

bind dual_bank_frontend dbf_checker #(.MIN_CYC(MIN_PULSE_CYC)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flash_sel_n (strb_s.flash_en_n),
  .sram_wr_win (sram_wr_win),
  .flash_wr_ok (flash_wr_ok),
  .standby     (standby),
  .fl_read_en  (fl_read_en),
  .fl_busy     (fl_busy),
  .fcmd_valid  (fcmd_valid),
  .fcmd_ready  (fcmd_ready),
  .fcmd_word   (32'({fcmd_addr, fcmd_data}))
);

// File: tb/test_dual_bank_frontend.sv
module test_dual_bank_frontend;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] host_addr = '0;
  logic [7:0]  host_din = '0;
  logic        host_flash_en_n = 1'b1;
  logic        host_sram_en_n = 1'b1;
  logic        host_we_n = 1'b1;
  logic        host_oe_n = 1'b1;
  logic [7:0]  host_dout;
  logic        host_dout_en;
  logic        standby;
  logic        fl_read_en;
  logic [18:0] fl_read_addr;
  logic [7:0]  fl_read_data;
  logic        fl_busy = 1'b0;
  logic        fcmd_valid;
  logic        fcmd_ready = 1'b0;
  logic [18:0] fcmd_addr;
  logic [7:0]  fcmd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // flash command unit model: read byte derived from address
  assign fl_read_data = fl_read_addr[7:0] ^ 8'h5A;

  dual_bank_frontend i_dual_bank_frontend (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    host_flash_en_n = 1'b1;
    host_sram_en_n  = 1'b1;
    host_we_n       = 1'b1;
    host_oe_n       = 1'b1;
    wait_n(4);
  endtask

  task automatic sram_write(input logic [18:0] a, input logic [7:0] d,
                            input bit oe_low, input bit sel_first);
    host_addr = a; host_din = d;
    host_oe_n = !oe_low;
    host_sram_en_n = 1'b0; host_we_n = 1'b0;
    wait_n(4);
    if (sel_first) host_sram_en_n = 1'b1; else host_we_n = 1'b1;
    wait_n(4);
    host_din = ~d;
    idle();
  endtask

  task automatic sram_read(input logic [18:0] a, output logic [7:0] d, output logic en);
    host_addr = a;
    host_sram_en_n = 1'b0; host_we_n = 1'b1; host_oe_n = 1'b0;
    wait_n(4);
    d = host_dout; en = host_dout_en;
    idle();
  endtask

  task automatic flash_pulse(input logic [18:0] a, input logic [7:0] d,
                             input int len, input bit oe_low, input bit sram_too);
    host_addr = a; host_din = d;
    host_oe_n = !oe_low;
    host_flash_en_n = 1'b0; host_sram_en_n = !sram_too;
    host_we_n = 1'b0;
    wait_n(len);
    host_we_n = 1'b1;
    wait_n(1);
    idle();
  endtask

  task automatic consume();
    fcmd_ready = 1'b1;
    wait_n(1);
    fcmd_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 dout_en", host_dout_en, 0);
    check("R11 fcmd_valid", fcmd_valid, 0);
    check("R11 standby", standby, 1);
  endtask

  task automatic t_standby();
    idle();
    host_oe_n = 1'b0;
    wait_n(4);
    check("R2 standby", standby, 1);
    check("R2 dout_en", host_dout_en, 0);
    check("R2 fl_read_en", fl_read_en, 0);
    idle();
  endtask

  task automatic t_sram_rw();
    logic [7:0] d; logic en;
    sram_write(19'h00012, 8'hA5, 1'b0, 1'b0);
    sram_read(19'h00012, d, en);
    check("R3 read data", d, 8'hA5);
    check("R3 dout_en", en, 1);
    sram_write(19'h00013, 8'h3C, 1'b1, 1'b0);
    sram_read(19'h00013, d, en);
    check("R4 write with oe low", d, 8'h3C);
    sram_write(19'h00014, 8'hC7, 1'b0, 1'b1);
    sram_read(19'h00014, d, en);
    check("R4 select ends window", d, 8'hC7);
  endtask

  task automatic t_alias();
    logic [7:0] d; logic en;
    sram_write(19'h00005, 8'h77, 1'b0, 1'b0);
    sram_read(19'h00405, d, en);
    check("R5 alias bit10", d, 8'h77);
    sram_read(19'h40005, d, en);
    check("R5 alias bit18", d, 8'h77);
  endtask

  task automatic t_oe_high();
    host_addr = 19'h00012;
    host_sram_en_n = 1'b0; host_we_n = 1'b1; host_oe_n = 1'b1;
    wait_n(4);
    check("R6 oe high no drive", host_dout_en, 0);
    idle();
  endtask

  task automatic t_both_enables();
    logic [7:0] d; logic en;
    sram_write(19'h00020, 8'h11, 1'b0, 1'b0);
    flash_pulse(19'h00020, 8'h99, 4, 1'b0, 1'b1);
    check("R1 flash cmd valid", fcmd_valid, 1);
    check("R1 flash cmd data", fcmd_data, 8'h99);
    consume();
    sram_read(19'h00020, d, en);
    check("R1 sram untouched", d, 8'h11);
    host_addr = 19'h00020;
    host_flash_en_n = 1'b0; host_sram_en_n = 1'b0; host_we_n = 1'b1; host_oe_n = 1'b0;
    wait_n(4);
    check("R1 read from flash", host_dout, 8'h20 ^ 8'h5A);
    idle();
  endtask

  task automatic t_inhibit();
    flash_pulse(19'h00100, 8'h42, 5, 1'b1, 1'b0);
    check("R7 oe low inhibits", fcmd_valid, 0);
    host_addr = 19'h00100; host_we_n = 1'b0; host_oe_n = 1'b1;
    wait_n(6);
    host_we_n = 1'b1;
    wait_n(2);
    idle();
    check("R7 select high inhibits", fcmd_valid, 0);
  endtask

  task automatic t_glitch();
    flash_pulse(19'h01234, 8'h5E, 2, 1'b0, 1'b0);
    check("R8 short pulse rejected", fcmd_valid, 0);
    flash_pulse(19'h01234, 8'h5E, 3, 1'b0, 1'b0);
    check("R8 min pulse accepted", fcmd_valid, 1);
    check("R8 cmd addr", fcmd_addr, 19'h01234);
    check("R8 cmd data", fcmd_data, 8'h5E);
    consume();
    check("R8 consumed", fcmd_valid, 0);
  endtask

  task automatic t_busy();
    logic [7:0] d; logic en;
    fl_busy = 1'b1;
    flash_pulse(19'h00200, 8'h66, 5, 1'b0, 1'b0);
    check("R9 cmd dropped while busy", fcmd_valid, 0);
    sram_write(19'h00030, 8'hE1, 1'b0, 1'b0);
    sram_read(19'h00030, d, en);
    check("R9 sram served while busy", d, 8'hE1);
    check("R9 sram drive while busy", en, 1);
    fl_busy = 1'b0;
  endtask

  task automatic t_handshake();
    flash_pulse(19'h00300, 8'hAA, 4, 1'b0, 1'b0);
    flash_pulse(19'h00301, 8'hBB, 4, 1'b0, 1'b0);
    check("R10 first held", fcmd_valid, 1);
    check("R10 first addr kept", fcmd_addr, 19'h00300);
    check("R10 first data kept", fcmd_data, 8'hAA);
    consume();
    wait_n(4);
    check("R10 second dropped", fcmd_valid, 0);
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(2);
    t_standby();
    t_sram_rw();
    t_alias();
    t_oe_high();
    t_both_enables();
    t_inhibit();
    t_glitch();
    t_busy();
    t_handshake();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule